// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises system software by counting down on a slow timebase tick and acting when the count runs out. Software keeps it from expiring in one of two ways. It can toggle a heartbeat input, and either edge of that input counts. It can also write the control fields. The timeout is set by a 3-bit code, and the count length doubles with each step of the code. A 2-bit action mode chooses what happens on expiry. The watchdog can stay silent, raise a warning interrupt, or raise a reset interrupt and pulse a system reset. In the two-stage mode it warns on the first expiry and resets on the next one, unless it is serviced in between.

When the chip is in hibernate, a configuration bit decides what the watchdog does. It either stops and freezes its count, or it keeps obeying its mode. The system reset output is held for a fixed number of clock cycles, so downstream logic sees a clean pulse of known length.

Top module: `wdog_escalate`

## Requirements
- R1: With mode 2'b00 the block never raises warn_irq, reset_irq or sys_rst, whatever ticks arrive.
- R2: With mode 2'b01, warn_irq pulses high for exactly one clock cycle on each expiry. The pulse falls in the cycle that follows the clock edge at which the expiring tick was sampled.
- R3: With mode 2'b10, each expiry gives a one-cycle reset_irq pulse in that same cycle and starts sys_rst.
- R4: With mode 2'b11, expiries alternate. The first gives warn_irq and the second gives reset_irq with sys_rst. Any heartbeat edge or host write in between returns the sequence to the warning step.
- R5: Timeout code n (0 to 5) gives an expiry after exactly 2^n ticks since the last reload. The reserved codes 3'b110 and 3'b111 act as code 5, which is 32 ticks.
- R6: A rising or a falling edge on hb_in reloads the count. The reload takes effect at the third clock edge after the input changes.
- R7: A strobe on wr_mode_en or wr_tmo_en loads the new field values and reloads the count from the new timeout. An expiry that would fall on the same cycle is dropped.
- R8: While hib is 1 and the stored hibernate-run bit is 0, ticks are ignored and the count is frozen. With that bit set to 1, the block follows its mode as when awake.
- R9: After reset, the mode is 2'b00, the timeout code is 3'b100 (16 ticks), the hibernate-run bit is 0 and all outputs are low.
- R10: sys_rst is high for RST_CYCLES (default 16) consecutive cycles, starting in the reset_irq cycle. A new reset expiry while it is high restarts the full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase pulse, one per 1/8 s |
| wr_mode_en | input | 1 | Strobe: load action mode and hibernate-run bit, reload count |
| wr_mode | input | 2 | Action mode value |
| wr_hib_run | input | 1 | Hibernate-run bit value (1 = keep running in hibernate) |
| wr_tmo_en | input | 1 | Strobe: load timeout code, reload count |
| wr_tmo | input | 3 | Timeout code value |
| hb_in | input | 1 | Asynchronous heartbeat; each edge reloads the count |
| hib | input | 1 | Chip is in hibernate |
| warn_irq | output | 1 | One-cycle warning interrupt |
| reset_irq | output | 1 | One-cycle reset interrupt |
| sys_rst | output | 1 | System reset, held RST_CYCLES cycles |

## Verification
An expiry shows on warn_irq or reset_irq one cycle after the edge that sampled the last tick. The bench therefore drives each tick for one falling-to-falling clock interval and reads the interrupts at the next falling edge. A heartbeat change needs three edges before it reloads, so the bench waits three falling edges after toggling hb_in before it sends a tick. sys_rst is measured as a run of high samples taken at falling edges. Its expected length is 16 for one expiry, and the tick spacing plus 16 when a second expiry restarts it. Expected interrupt counts per vector come from 2^n ticks per expiry and the mode rules.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_OFF       = 2'b00,
        WD_IRQ       = 2'b01,
        WD_RESET     = 2'b10,
        WD_TWO_STAGE = 2'b11
    } wd_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'b00,
        ACT_WARN  = 2'b01,
        ACT_RESET = 2'b10
    } wd_act_e;

    localparam int CODE_W = 3;
    localparam logic [CODE_W-1:0] CODE_DEFAULT = 3'b100;

    typedef struct packed {
        wd_mode_e          mode;
        logic [CODE_W-1:0] code;
        logic              hib_run;
    } wd_cfg_t;

    // Reserved codes above the largest legal one fall back to it.
    function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] c,
                                                     input int max_code);
        return (int'(c) > max_code) ? CODE_W'(max_code) : c;
    endfunction

endpackage

// File: rtl/wdog_hb_sync.sv
module wdog_hb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hb_in,
    output logic hb_edge
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], hb_in};
    end

    // Any change of the synchronized level is an edge.
    assign hb_edge = sh[STAGES-1] ^ sh[STAGES];
endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int MAX_CODE = 5,
    parameter int CNT_W    = MAX_CODE + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              run,
    input  logic              reload,
    input  logic [CODE_W-1:0] code_next,
    output logic              expire
);
    localparam logic [CNT_W-1:0] CNT_INIT =
        CNT_W'(1) << clamp_code(CODE_DEFAULT, MAX_CODE);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload_val;

    assign reload_val = CNT_W'(1) << clamp_code(code_next, MAX_CODE);
    assign expire     = run && tick && !reload && (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)                 cnt <= CNT_INIT;
        else if (reload)         cnt <= reload_val;
        else if (expire)         cnt <= reload_val;
        else if (run && tick)    cnt <= cnt - CNT_W'(1);
    end
endmodule

// File: rtl/wdog_action.sv
module wdog_action
    import wdog_pkg::*;
#(
    parameter int RST_CYCLES = 16,
    parameter int RST_W      = $clog2(RST_CYCLES + 1)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     expire,
    input  logic     clear,
    input  wd_mode_e mode,
    output logic     warn_irq,
    output logic     reset_irq,
    output logic     sys_rst
);
    logic             armed;
    logic [RST_W-1:0] rst_cnt;
    wd_act_e          act;

    always_comb begin
        unique case (mode)
            WD_IRQ:       act = ACT_WARN;
            WD_RESET:     act = ACT_RESET;
            WD_TWO_STAGE: act = armed ? ACT_RESET : ACT_WARN;
            default:      act = ACT_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            warn_irq  <= 1'b0;
            reset_irq <= 1'b0;
            armed     <= 1'b0;
            rst_cnt   <= '0;
        end else begin
            warn_irq  <= expire && (act == ACT_WARN);
            reset_irq <= expire && (act == ACT_RESET);
            if (clear)
                armed <= 1'b0;
            else if (expire && mode == WD_TWO_STAGE)
                armed <= !armed;
            if (expire && act == ACT_RESET)
                rst_cnt <= RST_W'(RST_CYCLES);
            else if (rst_cnt != '0)
                rst_cnt <= rst_cnt - RST_W'(1);
        end
    end

    assign sys_rst = (rst_cnt != '0);
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
    import wdog_pkg::*;
#(
    parameter int MAX_CODE    = 5,
    parameter int RST_CYCLES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       wr_mode_en,
    input  logic [1:0] wr_mode,
    input  logic       wr_hib_run,
    input  logic       wr_tmo_en,
    input  logic [2:0] wr_tmo,
    input  logic       hb_in,
    input  logic       hib,
    output logic       warn_irq,
    output logic       reset_irq,
    output logic       sys_rst
);
    wd_cfg_t cfg_q, cfg_d;
    logic    hb_edge, host_wr, reload, run, expire;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_mode_en) begin
            cfg_d.mode    = wd_mode_e'(wr_mode);
            cfg_d.hib_run = wr_hib_run;
        end
        if (wr_tmo_en)
            cfg_d.code = wr_tmo;
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '{mode: WD_OFF, code: CODE_DEFAULT, hib_run: 1'b0};
        else     cfg_q <= cfg_d;
    end

    assign host_wr = wr_mode_en || wr_tmo_en;
    assign reload  = host_wr || hb_edge;
    assign run     = (cfg_q.mode != WD_OFF) && (!hib || cfg_q.hib_run);

    wdog_hb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .hb_in(hb_in), .hb_edge(hb_edge)
    );

    wdog_count #(.MAX_CODE(MAX_CODE)) u_count (
        .clk(clk), .rst(rst), .tick(tick), .run(run), .reload(reload),
        .code_next(cfg_d.code), .expire(expire)
    );

    wdog_action #(.RST_CYCLES(RST_CYCLES)) u_action (
        .clk(clk), .rst(rst), .expire(expire), .clear(reload), .mode(cfg_q.mode),
        .warn_irq(warn_irq), .reset_irq(reset_irq), .sys_rst(sys_rst)
    );
endmodule

// File: rtl/wdog_escalate_chk.sv
module wdog_escalate_chk #(
    parameter int RST_CYCLES = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       hib,
    input logic       hib_run_q,
    input logic [1:0] mode_q,
    input logic       warn_irq,
    input logic       reset_irq,
    input logic       sys_rst
);
    localparam int HW = $clog2(RST_CYCLES + 1);
    logic [HW-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst)                                       hold <= '0;
        else if (reset_irq)                            hold <= HW'(1);
        else if (hold != '0 && int'(hold) < RST_CYCLES - 1) hold <= hold + HW'(1);
        else                                           hold <= '0;
    end

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        $past(mode_q == 2'b00) |-> (!warn_irq && !reset_irq)); // R1
    AST_WARN_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        warn_irq |-> $past(tick)); // R2
    AST_RESET_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        reset_irq |-> ($past(tick) && sys_rst)); // R3
    AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(warn_irq && reset_irq)); // R4
    AST_HIB_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(hib && !hib_run_q) |-> (!warn_irq && !reset_irq)); // R8
    AST_RST_WIDTH: assert property (@(posedge clk) disable iff (rst)
        sys_rst == (reset_irq || hold != '0)); // R10
endmodule

bind wdog_escalate wdog_escalate_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .hib(hib),
    .hib_run_q(cfg_q.hib_run), .mode_q(cfg_q.mode),
    .warn_irq(warn_irq), .reset_irq(reset_irq), .sys_rst(sys_rst)
);

// File: tb/sim_wdog_escalate.sv
module sim_wdog_escalate;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    logic       clk = 1'b0, rst = 1'b1, tick = 1'b0;
    logic       wr_mode_en = 1'b0, wr_hib_run = 1'b0, wr_tmo_en = 1'b0;
    logic [1:0] wr_mode = 2'b00;
    logic [2:0] wr_tmo = 3'b000;
    logic       hb_in = 1'b0, hib = 1'b0;
    logic       warn_irq, reset_irq, sys_rst;

    int n_chk = 0, n_fail = 0;
    int n_warn = 0, n_rst = 0, run_len = 0, last_len = 0;
    bit done = 0;

    // {mode[30:29], code[28:26], hib_run[25], hib[24], ticks[23:16], exp_warn[15:8], exp_rst[7:0]}
    localparam logic [30:0] VEC [NVEC] = '{
        {2'd1, 3'd0, 1'b0, 1'b0, 8'd5,  8'd5, 8'd0},
        {2'd1, 3'd2, 1'b0, 1'b0, 8'd9,  8'd2, 8'd0},
        {2'd1, 3'd4, 1'b0, 1'b0, 8'd16, 8'd1, 8'd0},
        {2'd2, 3'd1, 1'b0, 1'b0, 8'd6,  8'd0, 8'd3},
        {2'd3, 3'd0, 1'b0, 1'b0, 8'd4,  8'd2, 8'd2},
        {2'd3, 3'd1, 1'b0, 1'b0, 8'd7,  8'd2, 8'd1},
        {2'd0, 3'd0, 1'b0, 1'b0, 8'd6,  8'd0, 8'd0},
        {2'd1, 3'd7, 1'b0, 1'b0, 8'd32, 8'd1, 8'd0},
        {2'd1, 3'd6, 1'b0, 1'b0, 8'd31, 8'd0, 8'd0},
        {2'd1, 3'd5, 1'b0, 1'b0, 8'd64, 8'd2, 8'd0},
        {2'd1, 3'd0, 1'b0, 1'b1, 8'd3,  8'd0, 8'd0},
        {2'd1, 3'd0, 1'b1, 1'b1, 8'd3,  8'd3, 8'd0},
        {2'd2, 3'd0, 1'b1, 1'b0, 8'd2,  8'd0, 8'd2}
    };

    wdog_escalate u0 (
        .clk(clk), .rst(rst), .tick(tick),
        .wr_mode_en(wr_mode_en), .wr_mode(wr_mode), .wr_hib_run(wr_hib_run),
        .wr_tmo_en(wr_tmo_en), .wr_tmo(wr_tmo),
        .hb_in(hb_in), .hib(hib),
        .warn_irq(warn_irq), .reset_irq(reset_irq), .sys_rst(sys_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (warn_irq)  n_warn++;
            if (reset_irq) n_rst++;
            if (sys_rst) run_len++;
            else if (run_len != 0) begin last_len = run_len; run_len = 0; end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_once;
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_once();
            idle(1);
        end
    endtask

    task automatic wr(input logic en_m, input logic [1:0] m, input logic hr,
                      input logic en_t, input logic [2:0] c);
        @(negedge clk);
        wr_mode_en = en_m; wr_mode = m; wr_hib_run = hr;
        wr_tmo_en  = en_t; wr_tmo  = c;
        @(negedge clk);
        wr_mode_en = 1'b0; wr_tmo_en = 1'b0;
    endtask

    task automatic toggle_hb;
        @(negedge clk) hb_in = ~hb_in;
        idle(3);
    endtask

    function automatic string req_of(input int i);
        case (i)
            0: return "R2 vec";
            1, 2, 7, 8, 9: return "R5 vec";
            3, 12: return "R3 vec";
            4, 5: return "R4 vec";
            6: return "R1 vec";
            default: return "R8 vec";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_up();
    end

    initial begin
        int bw, br;
        idle(3);
        rst = 1'b0;
        idle(1);
        // R9: reset state and default timeout of 16 ticks
        check("R9 warn_irq after reset", warn_irq, 0);
        check("R9 reset_irq after reset", reset_irq, 0);
        check("R9 sys_rst after reset", sys_rst, 0);
        ticks(20);
        check("R9 default mode off", n_warn + n_rst, 0);
        wr(1'b1, 2'd1, 1'b0, 1'b0, 3'd0);
        bw = n_warn;
        ticks(15);
        check("R9 default code 15 ticks", n_warn - bw, 0);
        ticks(1);
        check("R9 default code 16 ticks", n_warn - bw, 1);

        // Vector walk
        for (int v = 0; v < NVEC; v++) begin
            hib = VEC[v][24];
            wr(1'b1, VEC[v][30:29], VEC[v][25], 1'b1, VEC[v][28:26]);
            idle(2);
            bw = n_warn; br = n_rst;
            ticks(int'(VEC[v][23:16]));
            idle(4);
            check($sformatf("%s %0d warn", req_of(v), v), n_warn - bw, int'(VEC[v][15:8]));
            check($sformatf("%s %0d reset", req_of(v), v), n_rst - br, int'(VEC[v][7:0]));
            hib = 1'b0;
            idle(20);
        end

        // R2: pulse timing and width
        wr(1'b1, 2'd1, 1'b0, 1'b1, 3'd0);
        idle(2);
        tick_once();
        check("R2 warn_irq in cycle after tick", warn_irq, 1);
        idle(1);
        check("R2 warn_irq one cycle only", warn_irq, 0);

        // R6: rising then falling heartbeat edge reloads
        wr(1'b1, 2'd1, 1'b0, 1'b1, 3'd2);
        bw = n_warn;
        ticks(3);
        toggle_hb();
        ticks(3);
        check("R6 rising edge reload", n_warn - bw, 0);
        ticks(1);
        check("R6 expiry after rising reload", n_warn - bw, 1);
        bw = n_warn;
        ticks(3);
        toggle_hb();
        ticks(3);
        check("R6 falling edge reload", n_warn - bw, 0);
        ticks(1);
        check("R6 expiry after falling reload", n_warn - bw, 1);

        // R7: host write reloads the count
        wr(1'b1, 2'd1, 1'b0, 1'b1, 3'd2);
        bw = n_warn;
        ticks(3);
        wr(1'b0, 2'd0, 1'b0, 1'b1, 3'd2);
        ticks(3);
        check("R7 write reload", n_warn - bw, 0);
        ticks(1);
        check("R7 expiry after write reload", n_warn - bw, 1);

        // R4: heartbeat returns two-stage sequence to the warning step
        wr(1'b1, 2'd3, 1'b0, 1'b1, 3'd0);
        bw = n_warn; br = n_rst;
        ticks(1);
        toggle_hb();
        ticks(1);
        check("R4 heartbeat clears first-expiry warn", n_warn - bw, 2);
        check("R4 heartbeat clears first-expiry reset", n_rst - br, 0);
        ticks(1);
        check("R4 second expiry resets", n_rst - br, 1);
        idle(20);

        // R7: host write also clears the first-expiry state
        wr(1'b1, 2'd3, 1'b0, 1'b1, 3'd0);
        bw = n_warn; br = n_rst;
        ticks(1);
        wr(1'b0, 2'd0, 1'b0, 1'b1, 3'd0);
        ticks(1);
        check("R7 write clears first-expiry warn", n_warn - bw, 2);
        check("R7 write clears first-expiry reset", n_rst - br, 0);

        // R10: system reset width, single and restarted
        wr(1'b1, 2'd2, 1'b0, 1'b1, 3'd0);
        idle(2);
        br = n_rst;
        tick_once();
        idle(25);
        check("R10 sys_rst width", last_len, 16);
        check("R3 single reset_irq pulse", n_rst - br, 1);
        tick_once();
        idle(3);
        tick_once();
        idle(30);
        check("R10 sys_rst restarted width", last_len, 21);

        finish_up();
    end
endmodule